// File: doc/BRIEF.md
# Sub-Banked CAM-Tag Data Cache

This block is a data cache split into equal sub-banks. Each access uses the address to pick exactly one sub-bank, and all the others stay idle. Inside the chosen sub-bank, every line's tag is compared with the request tag at the same time, so the sub-bank is fully associative. The resulting one-hot match vector drives the row enables of the data store directly. A hit is therefore known and answered in the same cycle as the request, and a store hit commits its bytes at the closing clock edge with no write buffer.

On a miss the cache stalls the requester by lowering `req_ready`. It asks a line-fill port for the missing line, takes the line's words in order into a chosen victim line, and then marks that line valid. The requester keeps its request on the port throughout. Once the fill ends, that same request hits.

Top module: `cam_cache`

## Requirements
- R1: Address fields, from least significant up, are: byte offset in bits [1:0], word offset in the next log2(LINE_WORDS) bits, sub-bank select in the next log2(NBANKS) bits, and tag in the remaining upper bits. A line held in one sub-bank never answers a request that names another sub-bank.
- R2: After reset every line is invalid, `req_ready` is 1, `refill_req` is 0, and the first access to any address misses.
- R3: `resp_hit` is 1 in the cycle in which `req_valid` and `req_ready` are both 1 and a valid line of the selected sub-bank holds the request tag. Otherwise `resp_hit` is 0.
- R4: On a read hit, `resp_rdata` in the same cycle carries the 32-bit word at the request's word offset within the matched line.
- R5: On a store hit (`req_we`=1), each byte lane b whose `req_be[b]` is 1 takes `req_wdata[8b+7:8b]` at the closing clock edge. Lanes with `req_be[b]`=0 keep their value.
- R6: A miss leaves the data array unchanged. From the next cycle, `refill_req` is 1, `req_ready` is 0, and `refill_addr` holds the request address with the word and byte offset bits zeroed. `refill_addr` stays stable until the fill ends.
- R7: The fill takes exactly LINE_WORDS beats, one on each cycle with `refill_valid`=1. Idle cycles may fall between beats, and beat k fills word k. In the cycle after the last beat, `req_ready` is 1, `refill_req` is 0, and the held request hits.
- R8: While `req_ready` is 0, no request hits and no store changes any line.
- R9: The victim of a fill is the lowest-numbered invalid line of the sub-bank. If every line is valid, it is the line named by that sub-bank's round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping modulo WAYS, after each pointer-chosen fill. WAYS must be a power of two.
- R10: At most one line of a sub-bank matches any tag. Fills and stores in one sub-bank leave the lines of every other sub-bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte-lane enables |
| req_ready | output | 1 | Cache can take a request (low during a fill) |
| resp_hit | output | 1 | Same-cycle hit indication |
| resp_rdata | output | 32 | Load data on hit |
| refill_req | output | 1 | Line fill wanted |
| refill_addr | output | ADDR_W | Line-aligned fill address |
| refill_valid | input | 1 | Fill beat present |
| refill_data | input | 32 | Fill beat word |

## Verification
The bench builds the cache with ADDR_W=16, NBANKS=2, WAYS=4 and LINE_WORDS=4, which gives an 11-bit tag and a 1-bit sub-bank select. With only four lines per sub-bank, a sweep of six to fourteen tags across both sub-banks fills every line. It then forces repeated round-robin evictions and pointer wraparound, so every hit, miss and victim outcome can be predicted by a small arithmetic model in the bench. The short lines keep each fill to a handful of cycles. That makes it cheap to fill with a gap between beats, to probe stalled stores during a fill, and to sweep every byte-enable pattern of interest over lines that are resident.

// File: rtl/cam_cache_pkg.sv
package cam_cache_pkg;

    typedef enum logic [0:0] {
        CC_LOOKUP = 1'b0,
        CC_FILL   = 1'b1
    } cc_state_e;

endpackage

// File: rtl/cam_victim_pick.sv
module cam_victim_pick #(
    parameter int WAYS  = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  line_valid,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             from_rr
);

    // Lowest-numbered invalid line wins; pointer only when all are valid.
    always_comb begin
        victim  = rr_ptr;
        from_rr = 1'b1;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!line_valid[i]) begin
                victim  = WAY_W'(i);
                from_rr = 1'b0;
            end
        end
    end

endmodule

// File: rtl/cam_tag_array.sv
module cam_tag_array #(
    parameter int NBANKS = 8,
    parameter int WAYS   = 32,
    parameter int TAG_W  = 24,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] srch_bank,
    input  logic [TAG_W-1:0]  srch_tag,
    input  logic              inst_we,
    input  logic [BANK_W-1:0] inst_bank,
    input  logic [WAY_W-1:0]  inst_way,
    input  logic [TAG_W-1:0]  inst_tag,
    output logic [WAYS-1:0]   match,
    output logic              hit,
    output logic [WAYS-1:0]   bank_valid
);

    logic [TAG_W-1:0]            tag_q [NBANKS][WAYS];
    logic [NBANKS-1:0][WAYS-1:0] vld_d, vld_q;

    // Parallel compare of every entry in the selected sub-bank only.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[srch_bank][w] && (tag_q[srch_bank][w] == srch_tag);
    end

    assign hit        = |match;
    assign bank_valid = vld_q[srch_bank];

    always_comb begin
        vld_d = vld_q;
        if (inst_we) begin
            vld_d[inst_bank][inst_way] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_we) begin
            tag_q[inst_bank][inst_way] <= inst_tag;
        end
    end

endmodule

// File: rtl/cam_data_array.sv
module cam_data_array #(
    parameter int NBANKS     = 8,
    parameter int WAYS       = 32,
    parameter int LINE_WORDS = 8,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WORD_W = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [WAYS-1:0]   row_en,
    input  logic              st_we,
    input  logic [3:0]        st_be,
    input  logic [31:0]       st_data,
    input  logic              fill_we,
    input  logic [BANK_W-1:0] fill_bank,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [WORD_W-1:0] fill_word,
    input  logic [31:0]       fill_data,
    output logic [31:0]       rd_data
);

    logic [31:0] mem_q [NBANKS][WAYS][LINE_WORDS];
    logic [31:0] row_word [WAYS];

    // Each row is gated by its own match line; no row drives on a miss.
    for (genvar w = 0; w < WAYS; w++) begin : g_row
        assign row_word[w] = mem_q[rd_bank][w][rd_word] & {32{row_en[w]}};
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            rd_data = rd_data | row_word[w];
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            mem_q[fill_bank][fill_way][fill_word] <= fill_data;
        end
        if (st_we) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int b = 0; b < 4; b++) begin
                    if (row_en[w] && st_be[b]) begin
                        mem_q[rd_bank][w][rd_word][8*b +: 8] <= st_data[8*b +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cam_cache.sv
module cam_cache
    import cam_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NBANKS     = 8,
    parameter int WAYS       = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              req_ready,
    output logic              resp_hit,
    output logic [31:0]       resp_rdata,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    input  logic              refill_valid,
    input  logic [31:0]       refill_data
);

    localparam int BYTE_W = 2;
    localparam int WORD_W = $clog2(LINE_WORDS);
    localparam int BANK_W = $clog2(NBANKS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - BYTE_W - WORD_W - BANK_W;
    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

    typedef struct packed {
        cc_state_e                   st;
        logic [WORD_W-1:0]           cnt;
        logic [BANK_W-1:0]           bank;
        logic [TAG_W-1:0]            tag;
        logic [WAY_W-1:0]            way;
        logic [NBANKS-1:0][WAY_W-1:0] rr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] a_word;
    logic [BANK_W-1:0] a_bank;
    logic [TAG_W-1:0]  a_tag;
    logic [WAYS-1:0]   way_match;
    logic [WAYS-1:0]   bank_valid;
    logic              tag_hit;
    logic [WAY_W-1:0]  victim;
    logic              victim_rr;
    logic              st_we;
    logic              fill_we;
    logic              inst_we;

    assign a_word = req_addr[BYTE_W +: WORD_W];
    assign a_bank = req_addr[BYTE_W + WORD_W +: BANK_W];
    assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];

    assign req_ready   = (ctl_q.st == CC_LOOKUP);
    assign resp_hit    = req_ready && req_valid && tag_hit;
    assign st_we       = resp_hit && req_we;
    assign refill_req  = (ctl_q.st == CC_FILL);
    assign refill_addr = {ctl_q.tag, ctl_q.bank, {(WORD_W + BYTE_W){1'b0}}};

    cam_tag_array #(
        .NBANKS (NBANKS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .srch_bank  (a_bank),
        .srch_tag   (a_tag),
        .inst_we    (inst_we),
        .inst_bank  (ctl_q.bank),
        .inst_way   (ctl_q.way),
        .inst_tag   (ctl_q.tag),
        .match      (way_match),
        .hit        (tag_hit),
        .bank_valid (bank_valid)
    );

    cam_victim_pick #(
        .WAYS (WAYS)
    ) u_victim (
        .line_valid (bank_valid),
        .rr_ptr     (ctl_q.rr[a_bank]),
        .victim     (victim),
        .from_rr    (victim_rr)
    );

    cam_data_array #(
        .NBANKS     (NBANKS),
        .WAYS       (WAYS),
        .LINE_WORDS (LINE_WORDS)
    ) u_data (
        .clk       (clk),
        .rd_bank   (a_bank),
        .rd_word   (a_word),
        .row_en    (way_match),
        .st_we     (st_we),
        .st_be     (req_be),
        .st_data   (req_wdata),
        .fill_we   (fill_we),
        .fill_bank (ctl_q.bank),
        .fill_way  (ctl_q.way),
        .fill_word (ctl_q.cnt),
        .fill_data (refill_data),
        .rd_data   (resp_rdata)
    );

    always_comb begin
        ctl_d   = ctl_q;
        fill_we = 1'b0;
        inst_we = 1'b0;
        case (ctl_q.st)
            CC_LOOKUP: begin
                if (req_valid && !tag_hit) begin
                    ctl_d.st   = CC_FILL;
                    ctl_d.cnt  = '0;
                    ctl_d.bank = a_bank;
                    ctl_d.tag  = a_tag;
                    ctl_d.way  = victim;
                    if (victim_rr) begin
                        ctl_d.rr[a_bank] = ctl_q.rr[a_bank] + 1'b1;
                    end
                end
            end
            CC_FILL: begin
                if (refill_valid) begin
                    fill_we   = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == LAST_BEAT) begin
                        inst_we  = 1'b1;
                        ctl_d.st = CC_LOOKUP;
                    end
                end
            end
            default: ctl_d.st = CC_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/cam_cache_chk.sv
module cam_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_hit,
    input logic              refill_req,
    input logic [ADDR_W-1:0] refill_addr,
    input logic              refill_valid,
    input logic [WAYS-1:0]   match_vec,
    input logic              store_we
);

    assert_one_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_miss_starts_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !resp_hit) |=> (refill_req && !req_ready));

    assert_fill_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> (!refill_req || $stable(refill_addr)));

    assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (!resp_hit && !store_we));

    assert_fill_ends_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refill_req) |-> ($past(refill_valid) && req_ready));

endmodule

bind cam_cache cam_cache_chk #(
    .ADDR_W (ADDR_W),
    .WAYS   (WAYS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_hit     (resp_hit),
    .refill_req   (refill_req),
    .refill_addr  (refill_addr),
    .refill_valid (refill_valid),
    .match_vec    (way_match),
    .store_we     (st_we)
);

// File: tb/cam_cache_test.sv
module cam_cache_test;

    localparam int AW = 16;
    localparam int NB = 2;
    localparam int NW = 4;
    localparam int LW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready;
    logic        resp_hit;
    logic [31:0] resp_rdata;
    logic        refill_req;
    logic [15:0] refill_addr;
    logic        refill_valid = 1'b0;
    logic [31:0] refill_data = '0;

    int checks = 0;
    int errors = 0;

    // Bench model of cache contents.
    logic [31:0] m_data [NB][NW][LW];
    logic [10:0] m_tag  [NB][NW];
    bit          m_vld  [NB][NW];
    int          m_rr   [NB];

    always #4 clk = ~clk;

    cam_cache #(
        .ADDR_W     (AW),
        .NBANKS     (NB),
        .WAYS       (NW),
        .LINE_WORDS (LW)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .req_ready    (req_ready),
        .resp_hit     (resp_hit),
        .resp_rdata   (resp_rdata),
        .refill_req   (refill_req),
        .refill_addr  (refill_addr),
        .refill_valid (refill_valid),
        .refill_data  (refill_data)
    );

    function automatic logic [31:0] backing(logic [15:0] a);
        return {a ^ 16'h5A5A, ~a};
    endfunction

    function automatic logic [15:0] mk(int tag, int bank, int word);
        return 16'((tag << 5) | (bank << 4) | (word << 2));
    endfunction

    function automatic int mdl_find(int bank, logic [10:0] tag);
        for (int w = 0; w < NW; w++) begin
            if (m_vld[bank][w] && m_tag[bank][w] == tag) return w;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic we, input logic [3:0] be,
                          input logic [31:0] wd, input bit stall, input logic [15:0] stall_a,
                          input string lbl);
        int bank;
        int word;
        int w;
        int vic;
        logic [10:0] tag;
        bank = int'(a[4]);
        word = int'(a[3:2]);
        tag  = a[15:5];
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
        #2;
        w = mdl_find(bank, tag);
        chk(resp_hit === (w >= 0), lbl, 32'(resp_hit), 32'(w >= 0));
        if (w < 0) begin
            vic = -1;
            for (int i = NW - 1; i >= 0; i--) if (!m_vld[bank][i]) vic = i;
            if (vic < 0) begin
                vic = m_rr[bank];
                m_rr[bank] = (m_rr[bank] + 1) % NW;
            end
            @(negedge clk);
            #1;
            chk(refill_req === 1'b1 && req_ready === 1'b0, "R6", {refill_req, req_ready}, 32'd2);
            chk(refill_addr === {a[15:4], 4'b0}, "R6", 32'(refill_addr), 32'({a[15:4], 4'b0}));
            if (stall) begin
                req_addr = stall_a; req_we = 1'b1; req_be = 4'hF; req_wdata = 32'hDEADBEEF;
                #1;
                chk(resp_hit === 1'b0, "R8", 32'(resp_hit), 32'd0);
                @(negedge clk);
                req_addr = a; req_we = we; req_be = be; req_wdata = wd;
            end
            for (int k = 0; k < LW; k++) begin
                if (k == 1) begin
                    refill_valid = 1'b0;
                    @(negedge clk);
                end
                refill_valid = 1'b1;
                refill_data  = backing({a[15:4], 2'(k), 2'b00});
                @(negedge clk);
            end
            refill_valid = 1'b0;
            #2;
            chk(req_ready === 1'b1 && refill_req === 1'b0, "R7", {req_ready, refill_req}, 32'd2);
            chk(resp_hit === 1'b1, "R7", 32'(resp_hit), 32'd1);
            for (int k = 0; k < LW; k++) m_data[bank][vic][k] = backing({a[15:4], 2'(k), 2'b00});
            m_tag[bank][vic] = tag;
            m_vld[bank][vic] = 1'b1;
            w = vic;
        end
        if (!we) begin
            chk(resp_rdata === m_data[bank][w][word], "R4", resp_rdata, m_data[bank][w][word]);
        end else begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) m_data[bank][w][word][8*b +: 8] = wd[8*b +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_rr[b] = 0;
            for (int w = 0; w < NW; w++) m_vld[b][w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R2: reset state
        chk(req_ready === 1'b1, "R2", 32'(req_ready), 32'd1);
        chk(refill_req === 1'b0, "R2", 32'(refill_req), 32'd0);
        chk(resp_hit === 1'b0, "R2", 32'(resp_hit), 32'd0);
        access(mk(0, 0, 0), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R2");

        // Read sweep with evictions (R3, R4, R9)
        for (int t = 0; t < 6; t++)
            for (int b = 0; b < NB; b++)
                for (int wd = 0; wd < LW; wd++)
                    access(mk(t, b, wd), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R3");
        access(mk(2, 0, 1), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R9");
        access(mk(0, 0, 1), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R9");
        access(mk(7, 0, 2), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R9");

        // R1: same tag, other sub-bank must miss
        access(mk(9, 1, 0), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R1");
        access(mk(9, 0, 0), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R1");

        // R5: byte-enable stores on hits, then read back
        for (int p = 0; p < 8; p++) begin
            logic [3:0] be;
            be = (p < 4) ? 4'(1 << p) : (p == 4 ? 4'b0011 : p == 5 ? 4'b1100 : p == 6 ? 4'b1111 : 4'b0000);
            access(mk(9, p % 2, p % LW), 1'b1, be, 32'h11223344 + 32'(p) * 32'h01010101,
                   1'b0, 16'h0, "R5");
            access(mk(9, p % 2, p % LW), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R5");
        end
        // store miss then replay write
        access(mk(12, 1, 3), 1'b1, 4'b0110, 32'hCAFEF00D, 1'b0, 16'h0, "R7");
        access(mk(12, 1, 3), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R5");

        // R8: store attempted during a fill is ignored
        access(mk(9, 1, 0), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R8");
        access(mk(13, 0, 0), 1'b0, 4'h0, 32'h0, 1'b1, mk(9, 1, 0), "R8");
        access(mk(9, 1, 0), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R8");

        // R10: re-sweep, every line and sub-bank consistent
        for (int t = 0; t < 14; t++)
            for (int b = 0; b < NB; b++) begin
                access(mk(t, b, 0), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R10");
                access(mk(t, b, 3), 1'b0, 4'h0, 32'h0, 1'b0, 16'h0, "R10");
            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule